// File: doc/BRIEF.md
# Sequential bfloat16 Multiplier

This block multiplies two bfloat16 numbers. Each operand arrives as a word twice the width of a bfloat16 value, with the value in the upper half and the lower half ignored. The result is returned in the same layout, with its lower half cleared. The product's sign and exponent are worked out combinationally when the operands are accepted. The two significands are then multiplied serially, one multiplier bit per clock, and the result is normalised by at most one position and rounded half up.

A caller pulses `start` with both operands valid while the block is idle. `busy` stays high while the product is being formed. A one-cycle `done` pulse marks the cycle in which `product` first holds the new result. `product` then keeps that value until the next completion. Exponent and fraction widths are parameters, and 8 and 7 give standard bfloat16. Special values (infinity, NaN, subnormals, exponent under- and overflow) get no treatment beyond a single zero rule, and the exponent wraps modulo its field width.

Top module: `bf16_serial_mul`

## Requirements
- R1: The product's top bit (bit WORD_W-1) is the XOR of the top bits of the two operands.
- R2: The product exponent field, at the EXP_W bits just below the sign, equals exponent A plus exponent B minus the bias 2^(EXP_W-1)-1, plus the increments of R4 and R6, taken modulo 2^EXP_W.
- R3: Each significand is the operand's FRAC_W fraction bits with a leading one prepended. Their exact product is built from a cleared accumulator over SIG_W=FRAC_W+1 steps. Each step examines one multiplier bit, most significant first, and adds a right-shifting copy of the multiplicand when that bit is one.
- R4: When the top bit of the 2*SIG_W-bit significand product is one, the fraction is taken one position higher and the exponent is raised by one.
- R5: The FRAC_W bits below the leading one, together with the next lower bit as round bit, are rounded by adding one at the round position and then dropping that position. Exact ties therefore round upward.
- R6: When rounding carries out past the leading one, the fraction becomes zero and the exponent is raised by one more.
- R7: The rounded fraction sits in the FRAC_W bits just below the exponent. The lower half of `product` is zero, and the lower halves of both operands have no effect.
- R8: When either operand has an exponent field of zero and a fraction field of zero, the product is a zero that carries the sign of R1.
- R9: `done` is high for exactly one cycle, SIG_W+1 rising edges after the edge that sampled `start`. `product` holds its value until the next completion.
- R10: `busy` is high from the edge after an accepted `start` until the edge that raises `done`. A `start` pulse while busy is ignored and changes neither the result nor its timing.
- R11: After reset, `busy`, `done` and `product` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Accept the operands (honoured only when idle) |
| op_a | input | WORD_W | Operand A, value in the upper half |
| op_b | input | WORD_W | Operand B, value in the upper half |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | One-cycle pulse: `product` is valid |
| product | output | WORD_W | Result, value in the upper half, lower half zero |

## Verification
The bench builds two instances. The first uses the default 8-bit exponent and 7-bit fraction and runs directed products: decimal-style values, a round-half-up tie, a rounding carry into the exponent, a signed zero and a start pulse issued while busy. The second uses a 4-bit exponent and a 3-bit fraction. At that size every pair of fractions, both signs of each operand and a spread of exponent pairs can all be run. This exercises both normalisation paths, every rounding outcome, exponent wrap and the zero rule, with results computed arithmetically in the bench.

// File: rtl/bf16_mul_pkg.sv
// Shared types for the serial bfloat16 multiplier.
// Assumes: nothing beyond a synthesizable enum.
package bf16_mul_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } bfm_state_e;
endpackage

// File: rtl/bfm_sign_exp.sv
// Sign, biased-exponent sum and zero detection for two packed values.
// Assumes: values are {sign, exponent, fraction}; exponent wraps modulo 2^EXP_W.
module bfm_sign_exp #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 7,
    localparam int VAL_W = 1 + EXP_W + FRAC_W
) (
    input  logic [VAL_W-1:0] val_a,
    input  logic [VAL_W-1:0] val_b,
    output logic             sign,
    output logic [EXP_W-1:0] exp_sum,
    output logic             is_zero
);
    localparam logic [EXP_W-1:0] BIAS = {1'b0, {(EXP_W-1){1'b1}}};

    logic [EXP_W-1:0]  exp_a, exp_b;
    logic [FRAC_W-1:0] frac_a, frac_b;

    // Split fields and form sign, exponent sum and zero flag.
    always_comb begin
        exp_a   = val_a[VAL_W-2 -: EXP_W];
        exp_b   = val_b[VAL_W-2 -: EXP_W];
        frac_a  = val_a[FRAC_W-1:0];
        frac_b  = val_b[FRAC_W-1:0];
        sign    = val_a[VAL_W-1] ^ val_b[VAL_W-1];
        exp_sum = exp_a + exp_b - BIAS;
        is_zero = ((exp_a == '0) && (frac_a == '0)) ||
                  ((exp_b == '0) && (frac_b == '0));
    end
endmodule

// File: rtl/bfm_sig_accum.sv
// Serial shift-add significand multiplier: one multiplier bit per step,
// MSB first, multiplicand shifted right after each step.
// Assumes: load and step are never high together; SIG_W steps follow a load.
module bfm_sig_accum #(
    parameter int SIG_W   = 8,
    localparam int PROD_W = 2 * SIG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [SIG_W-1:0]  sig_a,
    input  logic [SIG_W-1:0]  sig_b,
    output logic [PROD_W-1:0] acc
);
    logic [SIG_W-1:0]  mplier;
    logic [PROD_W-1:0] mcand;

    // Clear on load, conditionally add and shift on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mplier <= '0;
            mcand  <= '0;
            acc    <= '0;
        end else if (load) begin
            mplier <= sig_a;
            mcand  <= {1'b0, sig_b, {(SIG_W-1){1'b0}}};
            acc    <= '0;
        end else if (step) begin
            if (mplier[SIG_W-1]) acc <= acc + mcand;
            mcand  <= mcand >> 1;
            mplier <= mplier << 1;
        end
    end

    assert_acc_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (acc == '0));
    assert_acc_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (acc >= $past(acc)));
endmodule

// File: rtl/bfm_norm_round.sv
// Normalise a significand product by at most one place and round half up.
// Assumes: prod is the exact product of two significands with leading ones.
module bfm_norm_round #(
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 7,
    localparam int SIG_W  = FRAC_W + 1,
    localparam int PROD_W = 2 * SIG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [PROD_W-1:0] prod,
    input  logic [EXP_W-1:0]  exp_base,
    output logic [FRAC_W-1:0] frac_out,
    output logic [EXP_W-1:0]  exp_out
);
    logic             lead;
    logic [SIG_W:0]   tfield;
    logic [SIG_W:0]   rnd;
    logic             carry;

    // Pick the window below the leading one, round it and fix the exponent.
    always_comb begin
        lead     = prod[PROD_W-1];
        tfield   = lead ? prod[PROD_W-1 -: SIG_W+1] : prod[PROD_W-2 -: SIG_W+1];
        rnd      = {1'b0, tfield[SIG_W:1]} + {{SIG_W{1'b0}}, tfield[0]};
        carry    = rnd[SIG_W];
        frac_out = rnd[FRAC_W-1:0];
        exp_out  = exp_base + {{(EXP_W-1){1'b0}}, lead} + {{(EXP_W-1){1'b0}}, carry};
    end

    assert_prod_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (prod[PROD_W-1] | prod[PROD_W-2]));
    assert_lead_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (rnd[SIG_W] | rnd[SIG_W-1]));
    assert_round_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && carry) |-> (rnd[SIG_W-1:0] == '0));
endmodule

// File: rtl/bf16_serial_mul.sv
// Sequential bfloat16 multiplier top: accepts operands on start, multiplies
// significands serially over SIG_W cycles, then normalises, rounds and
// registers the result with a one-cycle done pulse.
// Assumes: values sit in the upper half of each word; lower halves ignored.
module bf16_serial_mul
    import bf16_mul_pkg::*;
#(
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 7,
    localparam int VAL_W  = 1 + EXP_W + FRAC_W,
    localparam int WORD_W = 2 * VAL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] product
);
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int CNT_W  = $clog2(SIG_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SIG_W - 1);

    bfm_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic              sign_q, zero_q;
    logic [EXP_W-1:0]  exp_q;
    logic              sign_n, zero_n;
    logic [EXP_W-1:0]  exp_n;
    logic [PROD_W-1:0] acc;
    logic [FRAC_W-1:0] frac_r;
    logic [EXP_W-1:0]  exp_r;
    logic              load, step;
    logic              unused_low_half;

    assign unused_low_half = ^{op_a[VAL_W-1:0], op_b[VAL_W-1:0]};
    assign load = (state == ST_IDLE) && start;
    assign step = (state == ST_RUN);
    assign busy = (state != ST_IDLE);

    bfm_sign_exp #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_sign_exp (
        .val_a   (op_a[WORD_W-1:VAL_W]),
        .val_b   (op_b[WORD_W-1:VAL_W]),
        .sign    (sign_n),
        .exp_sum (exp_n),
        .is_zero (zero_n)
    );

    bfm_sig_accum #(.SIG_W(SIG_W)) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .sig_a ({1'b1, op_a[VAL_W+FRAC_W-1:VAL_W]}),
        .sig_b ({1'b1, op_b[VAL_W+FRAC_W-1:VAL_W]}),
        .acc   (acc)
    );

    bfm_norm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (state == ST_FIN),
        .prod     (acc),
        .exp_base (exp_q),
        .frac_out (frac_r),
        .exp_out  (exp_r)
    );

    // Sequence idle -> run (SIG_W steps) -> finish, and register the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            sign_q  <= 1'b0;
            zero_q  <= 1'b0;
            exp_q   <= '0;
            done    <= 1'b0;
            product <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    state  <= ST_RUN;
                    cnt    <= '0;
                    sign_q <= sign_n;
                    zero_q <= zero_n;
                    exp_q  <= exp_n;
                end
                ST_RUN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) state <= ST_FIN;
                end
                ST_FIN: begin
                    product <= {sign_q,
                                zero_q ? {EXP_W{1'b0}}  : exp_r,
                                zero_q ? {FRAC_W{1'b0}} : frac_r,
                                {VAL_W{1'b0}}};
                    done    <= 1'b1;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_sign_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (product[WORD_W-1] == sign_q));
    assert_zero_rule_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && zero_q) |-> (product[WORD_W-2:0] == '0));
    assert_low_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (product[VAL_W-1:0] == '0));
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_idle_at_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && cnt != LAST) |=> (state == ST_RUN));
endmodule

// File: tb/test_bf16_serial_mul.sv
// Bench: directed products on the default size, sweep on a reduced size.
module test_bf16_serial_mul;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   errors = 0;
    int   checks = 0;
    int   cycles = 0;

    logic        start_b = 1'b0;
    logic [31:0] opa_b = '0, opb_b = '0;
    logic        busy_b, done_b;
    logic [31:0] prod_b;

    logic        start_s = 1'b0;
    logic [15:0] opa_s = '0, opb_s = '0;
    logic        busy_s, done_s;
    logic [15:0] prod_s;

    always #(CLK_PERIOD/2) clk = ~clk;

    bf16_serial_mul i_bf16_serial_mul (
        .clk(clk), .rst_n(rst_n), .start(start_b), .op_a(opa_b), .op_b(opb_b),
        .busy(busy_b), .done(done_b), .product(prod_b));

    bf16_serial_mul #(.EXP_W(4), .FRAC_W(3)) i_bf16_serial_mul_small (
        .clk(clk), .rst_n(rst_n), .start(start_s), .op_a(opa_s), .op_b(opb_s),
        .busy(busy_s), .done(done_s), .product(prod_s));

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WD_LIMIT) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run exceeded %0d cycles", WD_LIMIT);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic int model(int ew, int fw, int a, int b);
        int sa, sb, ea, eb, fa, fb, sgn, sw, p, lead, t, r, carry, e;
        sa = (a >> (ew + fw)) & 1;  sb = (b >> (ew + fw)) & 1;
        ea = (a >> fw) & ((1 << ew) - 1);  eb = (b >> fw) & ((1 << ew) - 1);
        fa = a & ((1 << fw) - 1);  fb = b & ((1 << fw) - 1);
        sgn = sa ^ sb;
        if ((ea == 0 && fa == 0) || (eb == 0 && fb == 0))
            return sgn << (ew + fw);
        sw = fw + 1;
        p = ((1 << fw) | fa) * ((1 << fw) | fb);
        lead = (p >> (2 * sw - 1)) & 1;
        t = p >> (sw - 2 + lead);
        r = (t + 1) >> 1;
        carry = (r >> sw) & 1;
        e = (ea + eb - ((1 << (ew - 1)) - 1) + lead + carry) & ((1 << ew) - 1);
        return (sgn << (ew + fw)) | (e << fw) | (r & ((1 << fw) - 1));
    endfunction

    task automatic check(string tag, longint got, longint exp);
        checks = checks + 1;
        if (got != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, got, exp);
        end
    endtask

    task automatic run_big(input logic [31:0] a, input logic [31:0] b,
                           output logic [31:0] res, output int lat);
        @(negedge clk);
        opa_b = a; opb_b = b; start_b = 1'b1;
        @(negedge clk);
        start_b = 1'b0; lat = 0;
        while (!done_b && lat < 40) begin @(negedge clk); lat++; end
        res = prod_b;
    endtask

    task automatic run_small(input logic [15:0] a, input logic [15:0] b,
                             output logic [15:0] res);
        int lat;
        @(negedge clk);
        opa_s = a; opb_s = b; start_s = 1'b1;
        @(negedge clk);
        start_s = 1'b0; lat = 0;
        while (!done_s && lat < 40) begin @(negedge clk); lat++; end
        res = prod_s;
    endtask

    task automatic big_prod(string tag, logic [31:0] a, logic [31:0] b, logic [31:0] exp);
        logic [31:0] res;
        int lat;
        run_big(a, b, res, lat);
        check(tag, res, exp);
    endtask

    initial begin
        logic [31:0] res;
        logic [15:0] rs;
        int lat;
        int ea_set[3];
        int eb_set[3];
        ea_set = '{1, 7, 14};
        eb_set = '{0, 7, 8};

        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 busy after reset", busy_b, 0);
        check("R11 done after reset", done_b, 0);
        check("R11 product after reset", prod_b, 0);
        check("R11 small product after reset", prod_s, 0);
        rst_n = 1'b1;

        // R9 latency, R10 busy, R2 plain exponent: 1.0 x 1.0
        @(negedge clk);
        opa_b = 32'h3F80_0000; opb_b = 32'h3F80_0000; start_b = 1'b1;
        @(negedge clk);
        start_b = 1'b0;
        check("R10 busy after start", busy_b, 1);
        lat = 0;
        while (!done_b && lat < 40) begin @(negedge clk); lat++; end
        check("R9 latency", lat, 9);
        check("R2 one times one", prod_b, 32'h3F80_0000);
        check("R10 idle at done", busy_b, 0);
        res = prod_b;
        @(negedge clk);
        check("R9 done single pulse", done_b, 0);
        check("R9 product held", prod_b, res);

        // R4: product top bit set, 1.5 x 1.5 = 2.25
        big_prod("R4 normalise 1.5*1.5", 32'h3FC0_0000, 32'h3FC0_0000, 32'h4010_0000);
        // R5: exact tie rounds up (1.5 x 1.0078125)
        big_prod("R5 tie rounds up", 32'h3FC0_0000, 32'h3F81_0000, 32'h3FC2_0000);
        // R6: rounding carry bumps exponent, fraction zero
        big_prod("R6 round carry", 32'h3FB5_0000, 32'h3FB5_0000, 32'h4000_0000);
        // R8: signed zero
        big_prod("R8 signed zero", 32'h8000_0000, 32'h4040_0000, 32'h8000_0000);
        // R1: negative times positive, sign XOR
        big_prod("R1 sign xor", 32'hC000_0000, 32'h4040_0000, 32'hC0C0_0000);
        // R3 R7: decimal-style values with nonzero lower halves ignored
        big_prod("R3 R7 12.1x45.6", 32'h4141_F9A7, 32'h4236_45A2,
                 32'(model(8, 7, 32'h4141, 32'h4236)) << 16);
        big_prod("R3 R7 1.3x99", 32'h3FA6_6666, 32'h42C6_3333,
                 32'(model(8, 7, 32'h3FA6, 32'h42C6)) << 16);
        big_prod("R3 R7 456x88.8", 32'h43E4_3A5E, 32'h42B1_999A,
                 32'(model(8, 7, 32'h43E4, 32'h42B1)) << 16);

        // R10: start while busy is ignored
        @(negedge clk);
        opa_b = 32'h4040_0000; opb_b = 32'h4040_0000; start_b = 1'b1;
        @(negedge clk);
        start_b = 1'b0; lat = 0;
        @(negedge clk); lat++;
        @(negedge clk); lat++;
        opa_b = 32'h4100_0000; opb_b = 32'h4120_0000; start_b = 1'b1;
        @(negedge clk); lat++;
        start_b = 1'b0;
        while (!done_b && lat < 40) begin @(negedge clk); lat++; end
        check("R10 ignored start latency", lat, 9);
        check("R10 ignored start result", prod_b, 32'h4110_0000);
        @(negedge clk);
        check("R10 no second run", busy_b, 0);

        // R1..R8: sweep of the reduced configuration
        for (int sa = 0; sa < 2; sa++)
            for (int sb = 0; sb < 2; sb++)
                for (int i = 0; i < 3; i++)
                    for (int j = 0; j < 3; j++)
                        for (int fa = 0; fa < 8; fa++)
                            for (int fb = 0; fb < 8; fb++) begin
                                int va, vb;
                                va = (sa << 7) | (ea_set[i] << 3) | fa;
                                vb = (sb << 7) | (eb_set[j] << 3) | fb;
                                run_small({8'(va), 8'(va ^ 8'h5A)},
                                          {8'(vb), 8'(vb ^ 8'hA5)}, rs);
                                check("R1-sweep R2 R3 R4 R5 R6 R7 R8", rs,
                                      16'(model(4, 3, va, vb)) << 8);
                            end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule